// File: doc/BRIEF.md
# SIMT Branch Divergence Mask Unit

This unit sequences the program counter and active-thread mask of one warp through two-way conditional branches. A warp is a group of threads, 32 by default, that share one instruction stream and execute in lockstep. For every instruction handed to the issue stage, the unit presents the current PC and the set of enabled threads. When the issued instruction is a branch, the decoder supplies a per-thread condition vector and three PCs: the taken target, the not-taken target and the reconvergence point.

If every active thread agrees on the condition, the unit simply redirects the PC and leaves the mask alone. If the active threads disagree, the taken side runs first with only its threads enabled. At the reconvergence PC the unit switches to the not-taken side with the complementary threads. When that side reaches the reconvergence PC as well, the full pre-branch mask is restored. Nested divergent branches are held on a small LIFO reconvergence stack. Pushing onto a full stack is a fault, which stops issue until the next launch.

The state machine has three states. `ST_IDLE` is the state after reset, and nothing is issued in it. `ST_RUN` is the issuing state. `ST_FAULT` is entered on a stack overflow. The transitions are as follows. Launch moves the machine from any state to `ST_RUN`. A divergent branch that finds the stack full moves it from `ST_RUN` to `ST_FAULT`. Within `ST_RUN`, a join cycle occurs whenever the PC equals the reconvergence PC on top of the stack. A join cycle either switches to the not-taken side or pops the entry.

Top module: `simt_div_unit`

## Requirements
- R1: During and after reset, `out_valid` is 0, `stk_overflow` is 0, and nothing is issued until `launch`.
- R2: One cycle after `launch`, `out_valid` is 1, `out_pc` equals `launch_pc`, `out_mask` equals `launch_mask`, the stack is empty and `stk_overflow` is 0. This holds in any state.
- R3: A non-branch instruction that is accepted (`out_valid` and `issue_ready` both 1, `br_valid` 0) advances `out_pc` by 1 and keeps `out_mask`. Without acceptance, PC and mask hold.
- R4: On an accepted branch where `out_mask & ~br_cond` is zero (uniform taken), `out_pc` becomes `br_taken_pc` and `out_mask` is unchanged. Condition bits of inactive threads have no effect.
- R5: On an accepted branch where `out_mask & br_cond` is zero and `out_mask & ~br_cond` is not zero (uniform not-taken), `out_pc` becomes `br_else_pc` and `out_mask` is unchanged.
- R6: On an accepted divergent branch (both derived masks non-zero), `out_pc` becomes `br_taken_pc` and `out_mask` becomes `out_mask & br_cond`.
- R7: When the PC of a taken side reaches its reconvergence PC, the unit spends one cycle with `out_valid` 0. It then presents `br_else_pc` with mask `pre-branch mask & ~br_cond`.
- R8: When the PC of a not-taken side reaches the reconvergence PC, the unit spends one cycle with `out_valid` 0. It then presents the reconvergence PC with the full pre-branch mask.
- R9: Nested divergent branches reconverge in LIFO order: the inner branch is resolved completely before the outer branch switches sides.
- R10: A divergent branch accepted while DEPTH entries are held sets `stk_overflow` to 1 and drops `out_valid` to 0. Both stay that way until the next `launch`. Exactly DEPTH nested divergent branches do not overflow.
- R11: `br_valid` and the branch fields have no effect in a cycle where `issue_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch | input | 1 | Start the warp at `launch_pc` with `launch_mask` |
| launch_pc | input | PCW | Start PC |
| launch_mask | input | W | Start thread mask |
| issue_ready | input | 1 | Issue stage accepts the presented instruction |
| br_valid | input | 1 | The presented instruction is a conditional branch |
| br_cond | input | W | Per-thread branch condition |
| br_taken_pc | input | PCW | Taken-side target |
| br_else_pc | input | PCW | Not-taken-side target |
| br_join_pc | input | PCW | Reconvergence PC |
| out_valid | output | 1 | An instruction is presented to the issue stage |
| out_pc | output | PCW | Current PC |
| out_mask | output | W | Current active mask |
| stk_overflow | output | 1 | Sticky reconvergence-stack overflow |

## Verification
The bench sets the condition bits of inactive threads to values that would flip the outcome if those bits were not masked. A unit that tested the raw condition would then take a divergent path, or the wrong side, on a branch that should be uniform. It times the join stall cycle by cycle. A unit that skipped the bubble, or switched sides one cycle late, would show a wrong PC or a raised valid at the sampled cycle. Nested branches check LIFO order: a stack that popped the wrong entry would restore the outer mask before the inner not-taken side has run. Finally, it nests exactly DEPTH branches and then one more. An off-by-one in the full test would either fault early or corrupt an entry silently.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FAULT
    } run_state_e;

    typedef enum logic [1:0] {
        SPLIT_TAKEN,
        SPLIT_ELSE,
        SPLIT_BOTH
    } split_kind_e;

endpackage

// File: rtl/simt_mask_split.sv
module simt_mask_split
    import simt_div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] act_mask,
    input  logic [W-1:0] cond,
    output logic [W-1:0] t_mask,
    output logic [W-1:0] n_mask,
    output split_kind_e  kind
);

    always_comb begin
        t_mask = act_mask & cond;
        n_mask = act_mask & ~cond;
        if (n_mask == '0)
            kind = SPLIT_TAKEN;
        else if (t_mask == '0)
            kind = SPLIT_ELSE;
        else
            kind = SPLIT_BOTH;
    end

endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack #(
    parameter int W     = 32,
    parameter int PCW   = 16,
    parameter int DEPTH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           push,
    input  logic [PCW-1:0] push_else_pc,
    input  logic [W-1:0]   push_else_mask,
    input  logic [PCW-1:0] push_join_pc,
    input  logic [W-1:0]   push_orig_mask,
    input  logic           pop,
    input  logic           flip,
    output logic [PCW-1:0] top_else_pc,
    output logic [W-1:0]   top_else_mask,
    output logic [PCW-1:0] top_join_pc,
    output logic [W-1:0]   top_orig_mask,
    output logic           top_phase,
    output logic           empty,
    output logic           full
);

    localparam int SPW  = $clog2(DEPTH + 1);
    localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PCW-1:0] else_pc;
        logic [W-1:0]   else_mask;
        logic [PCW-1:0] join_pc;
        logic [W-1:0]   orig_mask;
        logic           phase;
    } frame_t;

    frame_t         frames [DEPTH];
    logic [SPW-1:0] sp;
    logic [IDXW-1:0] top_idx;
    logic [IDXW-1:0] wr_idx;
    frame_t         top_f;

    assign empty   = (sp == '0);
    assign full    = (sp == SPW'(DEPTH));
    assign top_idx = IDXW'(sp - SPW'(1));
    assign wr_idx  = IDXW'(sp);
    assign top_f   = frames[top_idx];

    assign top_else_pc   = top_f.else_pc;
    assign top_else_mask = top_f.else_mask;
    assign top_join_pc   = top_f.join_pc;
    assign top_orig_mask = top_f.orig_mask;
    assign top_phase     = top_f.phase;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sp <= '0;
        end else if (push) begin
            sp <= sp + SPW'(1);
        end else if (pop) begin
            sp <= sp - SPW'(1);
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_frame
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    frames[g] <= '0;
                end else if (push && !clr && wr_idx == IDXW'(g)) begin
                    frames[g] <= '{push_else_pc, push_else_mask,
                                   push_join_pc, push_orig_mask, 1'b0};
                end else if (flip && !clr && top_idx == IDXW'(g)) begin
                    frames[g].phase <= 1'b1;
                end
            end
        end
    endgenerate

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop || flip) |-> !empty);

endmodule

// File: rtl/simt_div_unit.sv
module simt_div_unit
    import simt_div_pkg::*;
#(
    parameter int W     = 32,
    parameter int PCW   = 16,
    parameter int DEPTH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           launch,
    input  logic [PCW-1:0] launch_pc,
    input  logic [W-1:0]   launch_mask,
    input  logic           issue_ready,
    input  logic           br_valid,
    input  logic [W-1:0]   br_cond,
    input  logic [PCW-1:0] br_taken_pc,
    input  logic [PCW-1:0] br_else_pc,
    input  logic [PCW-1:0] br_join_pc,
    output logic           out_valid,
    output logic [PCW-1:0] out_pc,
    output logic [W-1:0]   out_mask,
    output logic           stk_overflow
);

    run_state_e     state_q, state_d;
    logic [PCW-1:0] pc_q, pc_d;
    logic [W-1:0]   mask_q, mask_d;
    logic           ovf_q, ovf_d;

    logic [W-1:0]   t_mask, n_mask;
    split_kind_e    kind;

    logic           s_push, s_pop, s_flip, s_clr;
    logic [PCW-1:0] top_else_pc, top_join_pc;
    logic [W-1:0]   top_else_mask, top_orig_mask;
    logic           top_phase, stk_empty, stk_full;

    logic           at_join, fire;

    simt_mask_split #(.W(W)) u_split (
        .act_mask (mask_q),
        .cond     (br_cond),
        .t_mask   (t_mask),
        .n_mask   (n_mask),
        .kind     (kind)
    );

    simt_reconv_stack #(.W(W), .PCW(PCW), .DEPTH(DEPTH)) u_stack (
        .clk            (clk),
        .rst_n          (rst_n),
        .clr            (s_clr),
        .push           (s_push),
        .push_else_pc   (br_else_pc),
        .push_else_mask (n_mask),
        .push_join_pc   (br_join_pc),
        .push_orig_mask (mask_q),
        .pop            (s_pop),
        .flip           (s_flip),
        .top_else_pc    (top_else_pc),
        .top_else_mask  (top_else_mask),
        .top_join_pc    (top_join_pc),
        .top_orig_mask  (top_orig_mask),
        .top_phase      (top_phase),
        .empty          (stk_empty),
        .full           (stk_full)
    );

    assign at_join = (state_q == ST_RUN) && !stk_empty && (pc_q == top_join_pc);

    // Output process
    always_comb begin
        out_valid    = (state_q == ST_RUN) && !at_join;
        out_pc       = pc_q;
        out_mask     = mask_q;
        stk_overflow = ovf_q;
    end

    assign fire = out_valid && issue_ready;

    // Next-state process
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        mask_d  = mask_q;
        ovf_d   = ovf_q;
        s_push  = 1'b0;
        s_pop   = 1'b0;
        s_flip  = 1'b0;
        s_clr   = 1'b0;
        if (launch) begin
            state_d = ST_RUN;
            pc_d    = launch_pc;
            mask_d  = launch_mask;
            ovf_d   = 1'b0;
            s_clr   = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_FAULT: ;
                ST_RUN: begin
                    if (at_join) begin
                        if (!top_phase) begin
                            pc_d   = top_else_pc;
                            mask_d = top_else_mask;
                            s_flip = 1'b1;
                        end else begin
                            pc_d   = top_join_pc;
                            mask_d = top_orig_mask;
                            s_pop  = 1'b1;
                        end
                    end else if (fire) begin
                        if (br_valid) begin
                            unique case (kind)
                                SPLIT_TAKEN: pc_d = br_taken_pc;
                                SPLIT_ELSE:  pc_d = br_else_pc;
                                SPLIT_BOTH: begin
                                    if (stk_full) begin
                                        state_d = ST_FAULT;
                                        ovf_d   = 1'b1;
                                    end else begin
                                        s_push = 1'b1;
                                        pc_d   = br_taken_pc;
                                        mask_d = t_mask;
                                    end
                                end
                                default: ;
                            endcase
                        end else begin
                            pc_d = pc_q + PCW'(1);
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
            mask_q  <= '0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            mask_q  <= mask_d;
            ovf_q   <= ovf_d;
        end
    end

    // R3
    seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !br_valid && !launch) |=> (out_pc == PCW'($past(out_pc) + PCW'(1))));

    // R4
    uniform_keep_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && br_valid && kind != SPLIT_BOTH && !launch) |=> $stable(out_mask));

    // R6
    div_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && br_valid && kind == SPLIT_BOTH && !stk_full && !launch)
        |=> ((out_mask & ~$past(out_mask)) == '0) && (out_mask != $past(out_mask)));

    // R10
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_overflow && !launch) |=> (stk_overflow && !out_valid));

    // R11
    no_ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !issue_ready && !launch) |=> ($stable(out_pc) && $stable(out_mask)));

endmodule

// File: tb/simt_div_unit_tb.sv
`timescale 1ns/1ps
module simt_div_unit_tb;

    localparam int W = 32, PCW = 16, DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic launch = 1'b0;
    logic [PCW-1:0] launch_pc = '0;
    logic [W-1:0] launch_mask = '0;
    logic issue_ready = 1'b0;
    logic br_valid = 1'b0;
    logic [W-1:0] br_cond = '0;
    logic [PCW-1:0] br_taken_pc = '0, br_else_pc = '0, br_join_pc = '0;
    logic out_valid, stk_overflow;
    logic [PCW-1:0] out_pc;
    logic [W-1:0] out_mask;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    simt_div_unit #(.W(W), .PCW(PCW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .launch(launch), .launch_pc(launch_pc),
        .launch_mask(launch_mask), .issue_ready(issue_ready), .br_valid(br_valid),
        .br_cond(br_cond), .br_taken_pc(br_taken_pc), .br_else_pc(br_else_pc),
        .br_join_pc(br_join_pc), .out_valid(out_valid), .out_pc(out_pc),
        .out_mask(out_mask), .stk_overflow(stk_overflow)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input logic v, input logic [PCW-1:0] pc,
                             input logic [W-1:0] m);
        chk({req, " valid"}, 64'(out_valid), 64'(v));
        chk({req, " pc"}, 64'(out_pc), 64'(pc));
        chk({req, " mask"}, 64'(out_mask), 64'(m));
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic do_launch(input logic [PCW-1:0] pc, input logic [W-1:0] m);
        launch = 1'b1; launch_pc = pc; launch_mask = m;
        cyc();
        launch = 1'b0;
    endtask

    task automatic issue(input int n);
        issue_ready = 1'b1; br_valid = 1'b0;
        for (int i = 0; i < n; i++) cyc();
        issue_ready = 1'b0;
    endtask

    task automatic branch(input logic [W-1:0] c, input logic [PCW-1:0] t,
                          input logic [PCW-1:0] e, input logic [PCW-1:0] j);
        issue_ready = 1'b1; br_valid = 1'b1;
        br_cond = c; br_taken_pc = t; br_else_pc = e; br_join_pc = j;
        cyc();
        issue_ready = 1'b0; br_valid = 1'b0;
    endtask

    task automatic t_reset();
        cyc();
        chk("R1 in reset valid", 64'(out_valid), 0);
        rst_n = 1'b1;
        cyc(); cyc();
        chk("R1 after reset valid", 64'(out_valid), 0);
        chk("R1 after reset ovf", 64'(stk_overflow), 0);
    endtask

    task automatic t_launch_seq();
        do_launch(16'h0010, 32'hFFFF_FFFF);
        chk_state("R2 launch", 1, 16'h0010, 32'hFFFF_FFFF);
        issue(3);
        chk_state("R3 advance", 1, 16'h0013, 32'hFFFF_FFFF);
        cyc();
        chk_state("R3 hold no ready", 1, 16'h0013, 32'hFFFF_FFFF);
        issue_ready = 1'b0; br_valid = 1'b1; br_cond = 32'h0000_00FF;
        br_taken_pc = 16'h0777; br_else_pc = 16'h0888; br_join_pc = 16'h0999;
        cyc();
        br_valid = 1'b0;
        chk_state("R11 branch ignored", 1, 16'h0013, 32'hFFFF_FFFF);
    endtask

    task automatic t_uniform();
        do_launch(16'h0040, 32'h0000_FFFF);
        branch(32'hABCD_FFFF, 16'h0050, 16'h0060, 16'h0070);
        chk_state("R4 uniform taken", 1, 16'h0050, 32'h0000_FFFF);
        branch(32'h1234_0000, 16'h0051, 16'h0061, 16'h0071);
        chk_state("R5 uniform else", 1, 16'h0061, 32'h0000_FFFF);
        issue(1);
        chk_state("R4 no push", 1, 16'h0062, 32'h0000_FFFF);
    endtask

    task automatic t_diverge();
        do_launch(16'h0020, 32'h0000_00FF);
        branch(32'hF000_000F, 16'h004E, 16'h004F, 16'h0050);
        chk_state("R6 taken side", 1, 16'h004E, 32'h0000_000F);
        issue(2);
        chk("R7 join bubble", 64'(out_valid), 0);
        cyc();
        chk_state("R7 else side", 1, 16'h004F, 32'h0000_00F0);
        issue(1);
        chk("R8 join bubble", 64'(out_valid), 0);
        cyc();
        chk_state("R8 restore", 1, 16'h0050, 32'h0000_00FF);
    endtask

    task automatic t_nest();
        do_launch(16'h0100, 32'h0000_00FF);
        branch(32'h0000_000F, 16'h0110, 16'h0120, 16'h0130);
        branch(32'h0000_0003, 16'h0118, 16'h011C, 16'h011E);
        chk_state("R9 inner taken", 1, 16'h0118, 32'h0000_0003);
        issue(6); cyc();
        chk_state("R9 inner else", 1, 16'h011C, 32'h0000_000C);
        issue(2); cyc();
        chk_state("R9 inner restore", 1, 16'h011E, 32'h0000_000F);
        issue(18);
        chk("R9 outer bubble", 64'(out_valid), 0);
        cyc();
        chk_state("R9 outer else", 1, 16'h0120, 32'h0000_00F0);
        issue(16); cyc();
        chk_state("R9 outer restore", 1, 16'h0130, 32'h0000_00FF);
    endtask

    task automatic t_overflow();
        logic [W-1:0] m;
        m = 32'hFFFF_FFFF;
        do_launch(16'h0200, m);
        for (int i = 0; i < DEPTH; i++) begin
            branch(m & (m - 1), PCW'(16'h0300 + i * 16), 16'h0500, PCW'(16'h0900 - i));
            m = m & (m - 1);
        end
        chk_state("R10 full no fault", 1, 16'h0370, m);
        chk("R10 full ovf", 64'(stk_overflow), 0);
        branch(m & (m - 1), 16'h0400, 16'h0500, 16'h0600);
        chk("R10 ovf set", 64'(stk_overflow), 1);
        chk("R10 valid low", 64'(out_valid), 0);
        issue(2);
        chk("R10 ovf sticky", 64'(stk_overflow), 1);
        do_launch(16'h0A00, 32'h0000_0001);
        chk("R2 launch clears ovf", 64'(stk_overflow), 0);
        chk_state("R2 relaunch", 1, 16'h0A00, 32'h0000_0001);
    endtask

    initial begin
        t_reset();
        t_launch_seq();
        t_uniform();
        t_diverge();
        t_nest();
        t_overflow();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(5 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule